// File: doc/BRIEF.md
# Pipelined YCbCr to RGB565 Colour Converter

This block turns a stream of 8-bit luma and chroma samples into packed 16-bit RGB565 pixels. It accepts one pixel on every pixel clock. Luma, blue-difference and red-difference chroma arrive on three separate 8-bit buses. A data-enable strobe, horizontal and vertical sync strobes and a field identifier come with them. Each pixel has its own chroma pair: any 4:2:2 upsampling is done before the block.

The datapath has four registered stages. The first removes the black level from luma and the mid-scale offset from both chroma samples. The second multiplies by fixed-point constant coefficients. The third sums, rounds and rescales. The fourth saturates each channel to 8 bits and packs it as 5/6/5. The four strobes pass through a matching four-register delay line, so every output word appears together with its own strobes. The block can sit between a video decoder front end and a display controller.

Top module: `ycc_to_rgb565`

## Requirements
- R1: The output word carries red in bits 15:11, green in bits 10:5 and blue in bits 4:0. Each field is the most significant bits of the saturated 8-bit channel: 5 bits of red, 6 bits of green and 5 bits of blue.
- R2: Red before saturation is floor((1192*(Y-16) + 1634*(Cr-128) + 512) / 1024), with all terms signed.
- R3: Green before saturation is floor((1192*(Y-16) - 833*(Cr-128) - 401*(Cb-128) + 512) / 1024).
- R4: Blue before saturation is floor((1192*(Y-16) + 2065*(Cb-128) + 512) / 1024).
- R5: Each channel saturates to 0..255. A negative result becomes 0 and a result above 255 becomes 255.
- R6: The word for a pixel applied before rising edge k appears on the output just after rising edge k+3, which is the fourth edge that registers it. A new pixel is accepted on every edge.
- R7: Data enable, horizontal sync, vertical sync and field ID come out on the same edge as the pixel they were applied with.
- R8: An active-high reset clears the output word and all four output strobes to zero at once, without waiting for a clock edge, and keeps them at zero while it is held.
- R9: Conversion runs whether or not data enable is high. A pixel applied with data enable low still gives its converted word, with the output data enable low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| in_den | input | 1 | Input data enable |
| in_hsync | input | 1 | Input horizontal sync |
| in_vsync | input | 1 | Input vertical sync |
| in_field | input | 1 | Input field identifier |
| in_y | input | 8 | Luma sample |
| in_cb | input | 8 | Blue-difference chroma sample |
| in_cr | input | 8 | Red-difference chroma sample |
| out_den | output | 1 | Delayed data enable, aligned with out_rgb |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_field | output | 1 | Delayed field identifier |
| out_rgb | output | 16 | Packed RGB565 pixel |

## Verification
Every converted word and its four strobes are due just after the fourth rising edge after the pixel is applied. The bench drives each pixel on a falling edge and reads the result on the fourth falling edge after that. In the streaming test it compares the word and strobes at each falling edge with the pixel driven four falling edges earlier, while the next pixel is being applied. The latency test also reads the three falling edges in between and expects them to show the previous pixel. The only result due without a clock edge is the cleared output on an asynchronous reset. It is read one nanosecond after reset rises, before the next rising edge.

// File: rtl/ycc_rgb_pkg.sv
package ycc_rgb_pkg;

    // sample and fixed-point geometry
    parameter int PIX_W   = 8;
    parameter int FRAC_W  = 10;
    parameter int OFF_W   = PIX_W + 1;
    parameter int COEF_W  = 13;
    parameter int PROD_W  = OFF_W + COEF_W;
    parameter int SUM_W   = PROD_W + 2;
    parameter int CHAN_W  = SUM_W - FRAC_W;

    // offsets removed from the incoming samples
    parameter int Y_BLACK = 16;
    parameter int C_MID   = 1 << (PIX_W - 1);

    // coefficients scaled by 2^FRAC_W
    parameter int K_LUMA  = 1192;
    parameter int K_R_CR  = 1634;
    parameter int K_G_CR  = 833;
    parameter int K_G_CB  = 401;
    parameter int K_B_CB  = 2065;
    parameter int ROUND   = 1 << (FRAC_W - 1);

    // output packing and pipeline depth
    parameter int R_W     = 5;
    parameter int G_W     = 6;
    parameter int B_W     = 5;
    parameter int RGB_W   = R_W + G_W + B_W;
    parameter int LAT     = 4;
    parameter int CHAN_MAX = (1 << PIX_W) - 1;

    typedef struct packed {
        logic signed [OFF_W-1:0] y;
        logic signed [OFF_W-1:0] cb;
        logic signed [OFF_W-1:0] cr;
    } offs_t;

    typedef struct packed {
        logic signed [PROD_W-1:0] luma;
        logic signed [PROD_W-1:0] r_cr;
        logic signed [PROD_W-1:0] g_cr;
        logic signed [PROD_W-1:0] g_cb;
        logic signed [PROD_W-1:0] b_cb;
    } prods_t;

    typedef struct packed {
        logic signed [CHAN_W-1:0] r;
        logic signed [CHAN_W-1:0] g;
        logic signed [CHAN_W-1:0] b;
    } chans_t;

    typedef struct packed {
        logic den;
        logic hs;
        logic vs;
        logic fid;
    } strobes_t;

endpackage

// File: rtl/ycc_offset_stage.sv
module ycc_offset_stage
    import ycc_rgb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] y_i,
    input  logic [PIX_W-1:0] cb_i,
    input  logic [PIX_W-1:0] cr_i,
    output offs_t            off_o
);

    offs_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.y  = $signed({1'b0, y_i})  - OFF_W'(Y_BLACK);
        st_d.cb = $signed({1'b0, cb_i}) - OFF_W'(C_MID);
        st_d.cr = $signed({1'b0, cr_i}) - OFF_W'(C_MID);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign off_o = st_q;

    // luma below the black level must leave this stage negative (R2)
    p_luma_below_black_r2: assert property (@(posedge clk) disable iff (rst)
        (y_i < PIX_W'(Y_BLACK)) |=> (st_q.y < 0));

endmodule

// File: rtl/ycc_product_stage.sv
module ycc_product_stage
    import ycc_rgb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  offs_t  off_i,
    output prods_t prod_o
);

    prods_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.luma = PROD_W'(off_i.y)  * PROD_W'(K_LUMA);
        st_d.r_cr = PROD_W'(off_i.cr) * PROD_W'(K_R_CR);
        st_d.g_cr = PROD_W'(off_i.cr) * PROD_W'(K_G_CR);
        st_d.g_cb = PROD_W'(off_i.cb) * PROD_W'(K_G_CB);
        st_d.b_cb = PROD_W'(off_i.cb) * PROD_W'(K_B_CB);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign prod_o = st_q;

    // a chroma sample above mid-scale gives a positive blue term (R4)
    p_blue_term_sign_r4: assert property (@(posedge clk) disable iff (rst)
        (off_i.cb > 0) |=> (st_q.b_cb > 0));

endmodule

// File: rtl/ycc_sum_stage.sv
module ycc_sum_stage
    import ycc_rgb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  prods_t prod_i,
    output chans_t chan_o
);

    chans_t st_d, st_q;
    logic signed [SUM_W-1:0] r_acc, g_acc, b_acc;

    always_comb begin
        r_acc  = SUM_W'(prod_i.luma) + SUM_W'(prod_i.r_cr) + SUM_W'(ROUND);
        g_acc  = SUM_W'(prod_i.luma) - SUM_W'(prod_i.g_cr)
               - SUM_W'(prod_i.g_cb) + SUM_W'(ROUND);
        b_acc  = SUM_W'(prod_i.luma) + SUM_W'(prod_i.b_cb) + SUM_W'(ROUND);
        st_d   = st_q;
        st_d.r = CHAN_W'(r_acc >>> FRAC_W);
        st_d.g = CHAN_W'(g_acc >>> FRAC_W);
        st_d.b = CHAN_W'(b_acc >>> FRAC_W);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign chan_o = st_q;

    // with no chroma terms the red and blue channels follow luma alone (R2)
    p_gray_balance_r2: assert property (@(posedge clk) disable iff (rst)
        (prod_i.r_cr == 0 && prod_i.b_cb == 0) |=> (st_q.r == st_q.b));

endmodule

// File: rtl/rgb_clip_pack.sv
module rgb_clip_pack
    import ycc_rgb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  chans_t           chan_i,
    output logic [RGB_W-1:0] rgb_o
);

    typedef struct packed {
        logic [RGB_W-1:0] word;
    } pack_st_t;

    pack_st_t st_d, st_q;
    logic [PIX_W-1:0] r8, g8, b8;

    function automatic logic [PIX_W-1:0] sat(input logic signed [CHAN_W-1:0] v);
        if (v < 0)             return '0;
        else if (v > CHAN_MAX) return PIX_W'(CHAN_MAX);
        else                   return PIX_W'(v);
    endfunction

    always_comb begin
        r8 = sat(chan_i.r);
        g8 = sat(chan_i.g);
        b8 = sat(chan_i.b);
        st_d      = st_q;
        st_d.word = {R_W'(r8 >> (PIX_W - R_W)),
                     G_W'(g8 >> (PIX_W - G_W)),
                     B_W'(b8 >> (PIX_W - B_W))};
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rgb_o = st_q.word;

    // overflow saturates red to its top code (R5)
    p_red_clip_high_r5: assert property (@(posedge clk) disable iff (rst)
        (chan_i.r > CHAN_MAX) |=> (rgb_o[RGB_W-1 -: R_W] == '1));

    // underflow saturates blue to zero (R5)
    p_blue_clip_low_r5: assert property (@(posedge clk) disable iff (rst)
        (chan_i.b < 0) |=> (rgb_o[B_W-1:0] == '0));

endmodule

// File: rtl/strobe_delay.sv
module strobe_delay
    import ycc_rgb_pkg::*;
#(
    parameter int DEPTH = LAT
) (
    input  logic     clk,
    input  logic     rst,
    input  strobes_t strb_i,
    output strobes_t strb_o
);

    strobes_t [DEPTH-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = strb_i;
        for (int i = 1; i < DEPTH; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign strb_o = st_q[DEPTH-1];

endmodule

// File: rtl/ycc_to_rgb565.sv
module ycc_to_rgb565
    import ycc_rgb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_den,
    input  logic              in_hsync,
    input  logic              in_vsync,
    input  logic              in_field,
    input  logic [PIX_W-1:0]  in_y,
    input  logic [PIX_W-1:0]  in_cb,
    input  logic [PIX_W-1:0]  in_cr,
    output logic              out_den,
    output logic              out_hsync,
    output logic              out_vsync,
    output logic              out_field,
    output logic [RGB_W-1:0]  out_rgb
);

    localparam int WARM_W = $clog2(LAT + 1);

    offs_t    off;
    prods_t   prod;
    chans_t   chan;
    strobes_t strb_in, strb_out;

    ycc_offset_stage u_offset (
        .clk   (clk),
        .rst   (rst),
        .y_i   (in_y),
        .cb_i  (in_cb),
        .cr_i  (in_cr),
        .off_o (off)
    );

    ycc_product_stage u_product (
        .clk    (clk),
        .rst    (rst),
        .off_i  (off),
        .prod_o (prod)
    );

    ycc_sum_stage u_sum (
        .clk    (clk),
        .rst    (rst),
        .prod_i (prod),
        .chan_o (chan)
    );

    rgb_clip_pack u_pack (
        .clk    (clk),
        .rst    (rst),
        .chan_i (chan),
        .rgb_o  (out_rgb)
    );

    assign strb_in = '{den: in_den, hs: in_hsync, vs: in_vsync, fid: in_field};

    strobe_delay #(.DEPTH(LAT)) u_strobes (
        .clk    (clk),
        .rst    (rst),
        .strb_i (strb_in),
        .strb_o (strb_out)
    );

    assign out_den   = strb_out.den;
    assign out_hsync = strb_out.hs;
    assign out_vsync = strb_out.vs;
    assign out_field = strb_out.fid;

    // edges since reset, saturating at the pipeline depth; guards the $past checks
    logic [WARM_W-1:0] warm_d, warm_q;

    always_comb begin
        warm_d = warm_q;
        if (warm_q != WARM_W'(LAT)) warm_d = warm_q + 1'b1;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) warm_q <= '0;
        else     warm_q <= warm_d;
    end

    p_strobe_align_r7: assert property (@(posedge clk) disable iff (rst)
        (warm_q == WARM_W'(LAT)) |->
            (out_den == $past(in_den, LAT) && out_hsync == $past(in_hsync, LAT) &&
             out_vsync == $past(in_vsync, LAT) && out_field == $past(in_field, LAT)));

    p_black_latency_r6: assert property (@(posedge clk) disable iff (rst)
        (warm_q == WARM_W'(LAT) && $past(in_y, LAT) == PIX_W'(Y_BLACK) &&
         $past(in_cb, LAT) == PIX_W'(C_MID) && $past(in_cr, LAT) == PIX_W'(C_MID))
            |-> (out_rgb == '0));

    p_reset_clear_r8: assert property (@(posedge clk)
        rst |-> (out_rgb == '0 && !out_den && !out_hsync && !out_vsync && !out_field));

endmodule

// File: tb/ycc_to_rgb565_bench.sv
module ycc_to_rgb565_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_den = 1'b0, in_hsync = 1'b0, in_vsync = 1'b0, in_field = 1'b0;
    logic [7:0] in_y = 8'd0, in_cb = 8'd0, in_cr = 8'd0;
    logic       out_den, out_hsync, out_vsync, out_field;
    logic [15:0] out_rgb;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ycc_to_rgb565 u_ycc_to_rgb565 (
        .clk(clk), .rst(rst),
        .in_den(in_den), .in_hsync(in_hsync), .in_vsync(in_vsync), .in_field(in_field),
        .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
        .out_den(out_den), .out_hsync(out_hsync), .out_vsync(out_vsync),
        .out_field(out_field), .out_rgb(out_rgb)
    );

    function automatic int clamp8(input int v);
        if (v < 0)   return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    // reference conversion written from R1..R5
    function automatic logic [15:0] model(input int y, input int cb, input int cr);
        int r, g, b;
        r = clamp8((1192*(y-16) + 1634*(cr-128) + 512) >>> 10);
        g = clamp8((1192*(y-16) - 833*(cr-128) - 401*(cb-128) + 512) >>> 10);
        b = clamp8((1192*(y-16) + 2065*(cb-128) + 512) >>> 10);
        return {5'(r >> 3), 6'(g >> 2), 5'(b >> 3)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input int y, input int cb, input int cr, input logic [3:0] s);
        in_y = 8'(y); in_cb = 8'(cb); in_cr = 8'(cr);
        {in_den, in_hsync, in_vsync, in_field} = s;
    endtask

    // one pixel in, result read on the fourth falling edge
    task automatic one_pixel(input string req, input int y, input int cb, input int cr);
        @(negedge clk);
        drive(y, cb, cr, 4'b1000);
        repeat (4) @(negedge clk);
        check(req, 32'(out_rgb), 32'(model(y, cb, cr)));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        drive(200, 30, 220, 4'b1111);
        repeat (3) @(negedge clk);
        check("R8 reset word", 32'(out_rgb), 32'h0);
        check("R8 reset strobes", 32'({out_den, out_hsync, out_vsync, out_field}), 32'h0);
        drive(16, 128, 128, 4'b0000);
        rst = 1'b0;
    endtask

    task automatic t_colours;
        one_pixel("R1 black", 16, 128, 128);
        check("R1 black literal", 32'(out_rgb), 32'h0000);
        one_pixel("R1 white", 235, 128, 128);
        check("R1 white literal", 32'(out_rgb), 32'hFFFF);
        one_pixel("R2 red", 81, 90, 240);
        one_pixel("R3 green", 145, 54, 34);
        one_pixel("R4 blue", 41, 240, 110);
        one_pixel("R3 mid gray", 126, 128, 128);
    endtask

    task automatic t_extremes;
        one_pixel("R5 all high", 255, 255, 255);
        one_pixel("R5 all low", 0, 0, 0);
        one_pixel("R5 red over", 255, 0, 255);
        check("R5 red field saturated", 32'(out_rgb[15:11]), 32'h1F);
        one_pixel("R5 blue under", 0, 0, 255);
        check("R5 blue field zero", 32'(out_rgb[4:0]), 32'h0);
    endtask

    task automatic t_latency;
        @(negedge clk);
        drive(16, 128, 128, 4'b0000);
        repeat (4) @(negedge clk);
        drive(235, 128, 128, 4'b1000);
        @(negedge clk);
        drive(16, 128, 128, 4'b0000);
        check("R6 edge1 still old", 32'(out_rgb), 32'h0);
        @(negedge clk);
        check("R6 edge2 still old", 32'(out_rgb), 32'h0);
        @(negedge clk);
        check("R6 edge3 still old", 32'(out_rgb), 32'h0);
        @(negedge clk);
        check("R6 edge4 new word", 32'(out_rgb), 32'hFFFF);
        check("R7 den with word", 32'(out_den), 32'h1);
        @(negedge clk);
        check("R6 next word", 32'(out_rgb), 32'h0);
        check("R7 den follows", 32'(out_den), 32'h0);
    endtask

    task automatic t_stream;
        logic [15:0] exp_w [24];
        logic [3:0]  exp_s [24];
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (i >= 4) begin
                check("R6 stream word", 32'(out_rgb), 32'(exp_w[i-4]));
                check("R7 stream strobes",
                      32'({out_den, out_hsync, out_vsync, out_field}), 32'(exp_s[i-4]));
            end
            if (i < 20) begin
                exp_w[i] = model((i*37+5) % 256, (i*91+200) % 256, (i*53+17) % 256);
                exp_s[i] = 4'((i * 7) ^ (i >> 1));
                drive((i*37+5) % 256, (i*91+200) % 256, (i*53+17) % 256, exp_s[i]);
            end else begin
                drive(16, 128, 128, 4'b0000);
            end
        end
    endtask

    task automatic t_den_low;
        @(negedge clk);
        drive(81, 90, 240, 4'b0110);
        repeat (4) @(negedge clk);
        check("R9 word with den low", 32'(out_rgb), 32'(model(81, 90, 240)));
        check("R9 den stays low", 32'({out_den, out_hsync, out_vsync, out_field}), 32'h6);
    endtask

    task automatic t_async_reset;
        @(negedge clk);
        drive(235, 128, 128, 4'b1111);
        repeat (4) @(negedge clk);
        check("R8 word before reset", 32'(out_rgb), 32'hFFFF);
        #2 rst = 1'b1;
        #1;
        check("R8 async word clear", 32'(out_rgb), 32'h0);
        check("R8 async strobe clear", 32'({out_den, out_hsync, out_vsync, out_field}), 32'h0);
        @(negedge clk);
        rst = 1'b0;
        drive(16, 128, 128, 4'b0000);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_colours();
        t_extremes();
        t_latency();
        t_stream();
        t_den_low();
        t_async_reset();
        one_pixel("R2 after reset", 81, 90, 240);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule